// File: doc/BRIEF.md
# User-to-Host Dual-Clock Pipe FIFO

This block carries 64-bit words from user logic running on its own clock to a host running on a separate clock. The user side pushes words into a 511-entry asynchronous FIFO and sees a full flag and a fill count. It also sees one-cycle pulses that mark the start and the end of each host transfer. The host side opens a transfer of a chosen word length and then pulls words through a valid/ready output. A transfer always runs to its requested length. If the FIFO runs dry, the host gets zero filler words and a sticky underrun flag.

The user-side write port works as valid/ready. `u_wr` is the valid. The inverse of `u_full` is the ready. A word is taken only on a user clock edge where `u_wr` is high, `u_full` is low and `u_fifo_rst` is low. Any other write is dropped.

The host-side output is also valid/ready. `h_out_valid` is high while words of the open transfer remain. A beat happens on each host clock edge where both `h_out_valid` and `h_out_ready` are high. The host may hold `h_out_ready` low to pause; the data and the remaining length stay put while it does. Pointers cross between the clocks in Gray code through two-flop synchronisers. Transfer start, end and FIFO-flush events cross as toggles.

Top module: `u2h_pipe_fifo`

## Requirements
- R1: After reset, `u_full`, `u_count`, `u_start`, `u_done`, `h_out_valid` and `h_underrun` are all 0.
- R2: A `h_start` with a nonzero `h_len`, while no transfer is open, gives exactly one `u_start` pulse one user cycle wide. A `h_start` with `h_len` = 0, or while a transfer is open, is ignored: no pulse appears, and the open length is unchanged.
- R3: After an accepted start, `h_out_valid` stays high for exactly `h_len` beats. The words come out in the order they were written.
- R4: Once both clocks have run about ten cycles with no activity, `u_count` equals the words written minus the words the host has popped. The count may transiently over-report the fill level but never under-reports it.
- R5: `u_full` is high when 511 words are held, and `u_count` then reads 511. A write attempted while `u_full` is high is discarded: it neither raises the count nor reaches the host.
- R6: A pulse on `u_fifo_rst` keeps `u_full` high for at least 3 user cycles. All held words are dropped, and when `u_full` falls, `u_count` is 0. Writes made during the flush are discarded.
- R7: A beat taken while the FIFO is empty returns all-zero data and sets `h_underrun`. The flag stays high after the transfer ends and clears only when the next start is accepted.
- R8: After the last beat of a transfer, `u_done` pulses exactly once, one user cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| u_clk | input | 1 | User-side clock |
| u_rst_n | input | 1 | User-side asynchronous reset, active low |
| u_wr | input | 1 | Write valid |
| u_data | input | 64 | Write data |
| u_fifo_rst | input | 1 | Request to flush the FIFO |
| u_full | output | 1 | FIFO cannot take a word (inverse ready) |
| u_count | output | 9 | Words held, as seen from the user side |
| u_start | output | 1 | One-cycle pulse: host opened a transfer |
| u_done | output | 1 | One-cycle pulse: host finished a transfer |
| h_clk | input | 1 | Host-side clock |
| h_rst_n | input | 1 | Host-side asynchronous reset, active low |
| h_start | input | 1 | Open a transfer of `h_len` words |
| h_len | input | 16 | Requested transfer length in words |
| h_out_ready | input | 1 | Host takes a word this cycle |
| h_out_valid | output | 1 | Words of the open transfer remain |
| h_out_data | output | 64 | Word at the head of the FIFO, or zero when empty |
| h_underrun | output | 1 | Sticky: a beat found the FIFO empty |

## Verification
The bench fills the FIFO to exactly 511 words and pushes one more. A design with an off-by-one full test would either stall at 510 or let the extra word reach the host, which a 512-beat read then exposes. Flushes are issued with writes still active. A design that ended the flush before the read pointer had caught up would show a nonzero count or replay stale words. Transfers longer than the stored data check that filler is zero and that the underrun flag survives until the next start. Repeated and zero-length starts check that a start is not accepted twice or lengthened mid-transfer.

// File: rtl/pipe_fifo_pkg.sv
package pipe_fifo_pkg;
  localparam int PF_AW  = 9;                 // address bits of the storage
  localparam int PF_CAP = (1 << PF_AW) - 1;  // usable entries (511)

  typedef logic [PF_AW:0] ptr_t;             // pointer with wrap bit

  function automatic ptr_t bin2gray(input ptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr_t gray2bin(input ptr_t g);
    ptr_t b;
    b[PF_AW] = g[PF_AW];
    for (int i = PF_AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/pf_sync.sv
module pf_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pf_wr_side.sv
module pf_wr_side
  import pipe_fifo_pkg::*;
#(
  parameter int MIN_RST = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic             flush_i,
  output logic             full_o,
  output logic [PF_AW-1:0] count_o,
  output logic             start_o,
  output logic             done_o,
  output logic             mem_we_o,
  output logic [PF_AW-1:0] mem_addr_o,
  output ptr_t             wgray_o,
  input  ptr_t             rgray_i,
  input  logic             start_tgl_i,
  input  logic             done_tgl_i,
  output logic             flush_tgl_o,
  input  logic             ack_tgl_i
);
  localparam int HW = $clog2(MIN_RST) + 1;

  ptr_t          wbin, rsync_g, rsync_b, diff;
  logic          st_s, st_d, dn_s, dn_d, ack_s;
  logic          flushing, room_full, ack_ok;
  logic [HW-1:0] hold;

  pf_sync #(.W(PF_AW + 1)) u_rsync (.clk(clk), .rst_n(rst_n), .d(rgray_i), .q(rsync_g));
  pf_sync #(.W(1)) u_ssync (.clk(clk), .rst_n(rst_n), .d(start_tgl_i), .q(st_s));
  pf_sync #(.W(1)) u_dsync (.clk(clk), .rst_n(rst_n), .d(done_tgl_i), .q(dn_s));
  pf_sync #(.W(1)) u_async (.clk(clk), .rst_n(rst_n), .d(ack_tgl_i), .q(ack_s));

  always_comb begin
    rsync_b    = gray2bin(rsync_g);
    diff       = wbin - rsync_b;
    room_full  = (diff >= ptr_t'(PF_CAP));
    full_o     = flushing | room_full;
    count_o    = diff[PF_AW-1:0];
    mem_we_o   = wr_i & ~full_o & ~flush_i;
    mem_addr_o = wbin[PF_AW-1:0];
    ack_ok     = (ack_s == flush_tgl_o);
    start_o    = st_s ^ st_d;
    done_o     = dn_s ^ dn_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin        <= '0;
      wgray_o     <= '0;
      st_d        <= 1'b0;
      dn_d        <= 1'b0;
      flushing    <= 1'b0;
      flush_tgl_o <= 1'b0;
      hold        <= '0;
    end else begin
      st_d <= st_s;
      dn_d <= dn_s;
      if (mem_we_o) begin
        wbin    <= wbin + 1'b1;
        wgray_o <= bin2gray(wbin + 1'b1);
      end
      if (flush_i) begin
        if (!flushing) flush_tgl_o <= ~flush_tgl_o;
        flushing <= 1'b1;
        hold     <= HW'(MIN_RST - 1);
      end else if (flushing) begin
        if (hold != '0) hold <= hold - 1'b1;
        else if (ack_ok) flushing <= 1'b0;
      end
    end
  end

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && full_o) |=> $stable(wbin));
  a_r4_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    diff <= ptr_t'(PF_CAP));
  a_r6_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flushing) |=> flushing ##1 flushing);
endmodule

// File: rtl/pf_rd_side.sv
module pf_rd_side
  import pipe_fifo_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              underrun_o,
  output logic [PF_AW-1:0]  mem_addr_o,
  input  logic [DATA_W-1:0] mem_data_i,
  output ptr_t              rgray_o,
  input  ptr_t              wgray_i,
  output logic              start_tgl_o,
  output logic              done_tgl_o,
  input  logic              flush_tgl_i,
  output logic              ack_tgl_o
);
  ptr_t             rbin, rbin_nx, wsync_g, wsync_b;
  logic [LEN_W-1:0] remaining;
  logic             rq_s, rq_d, flush_edge, empty, beat, take;

  pf_sync #(.W(PF_AW + 1)) u_wsync (.clk(clk), .rst_n(rst_n), .d(wgray_i), .q(wsync_g));
  pf_sync #(.W(1)) u_fsync (.clk(clk), .rst_n(rst_n), .d(flush_tgl_i), .q(rq_s));

  always_comb begin
    wsync_b    = gray2bin(wsync_g);
    empty      = (rbin == wsync_b);
    valid_o    = (remaining != '0);
    beat       = valid_o & ready_i;
    take       = start_i & ~valid_o & (len_i != '0);
    flush_edge = rq_s ^ rq_d;
    mem_addr_o = rbin[PF_AW-1:0];
    data_o     = empty ? '0 : mem_data_i;
    if (flush_edge)          rbin_nx = wsync_b;
    else if (beat && !empty) rbin_nx = rbin + 1'b1;
    else                     rbin_nx = rbin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin        <= '0;
      rgray_o     <= '0;
      remaining   <= '0;
      underrun_o  <= 1'b0;
      start_tgl_o <= 1'b0;
      done_tgl_o  <= 1'b0;
      rq_d        <= 1'b0;
      ack_tgl_o   <= 1'b0;
    end else begin
      rq_d      <= rq_s;
      ack_tgl_o <= rq_d;
      rbin      <= rbin_nx;
      rgray_o   <= bin2gray(rbin_nx);
      if (take) begin
        remaining   <= len_i;
        underrun_o  <= 1'b0;
        start_tgl_o <= ~start_tgl_o;
      end else if (beat) begin
        remaining <= remaining - 1'b1;
        if (empty) underrun_o <= 1'b1;
        if (remaining == LEN_W'(1)) done_tgl_o <= ~done_tgl_o;
      end
    end
  end

  a_r3_len_down: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ready_i) |=> remaining == LEN_W'($past(remaining) - 1'b1));
  a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ready_i && empty) |=> underrun_o);
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun_o && !take) |=> underrun_o);
endmodule

// File: rtl/u2h_pipe_fifo.sv
module u2h_pipe_fifo
  import pipe_fifo_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int LEN_W   = 16,
  parameter int MIN_RST = 3
) (
  input  logic              u_clk,
  input  logic              u_rst_n,
  input  logic              u_wr,
  input  logic [DATA_W-1:0] u_data,
  input  logic              u_fifo_rst,
  output logic              u_full,
  output logic [PF_AW-1:0]  u_count,
  output logic              u_start,
  output logic              u_done,
  input  logic              h_clk,
  input  logic              h_rst_n,
  input  logic              h_start,
  input  logic [LEN_W-1:0]  h_len,
  input  logic              h_out_ready,
  output logic              h_out_valid,
  output logic [DATA_W-1:0] h_out_data,
  output logic              h_underrun
);
  localparam int DEPTH = 1 << PF_AW;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              we;
  logic [PF_AW-1:0]  waddr, raddr;
  ptr_t              wgray, rgray;
  logic              st_tgl, dn_tgl, fl_tgl, ack_tgl;

  always_ff @(posedge u_clk) begin
    if (we) mem[waddr] <= u_data;
  end

  pf_wr_side #(.MIN_RST(MIN_RST)) u_wr_side (
    .clk(u_clk), .rst_n(u_rst_n), .wr_i(u_wr), .flush_i(u_fifo_rst),
    .full_o(u_full), .count_o(u_count), .start_o(u_start), .done_o(u_done),
    .mem_we_o(we), .mem_addr_o(waddr), .wgray_o(wgray), .rgray_i(rgray),
    .start_tgl_i(st_tgl), .done_tgl_i(dn_tgl), .flush_tgl_o(fl_tgl), .ack_tgl_i(ack_tgl)
  );

  pf_rd_side #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_rd_side (
    .clk(h_clk), .rst_n(h_rst_n), .start_i(h_start), .len_i(h_len),
    .ready_i(h_out_ready), .valid_o(h_out_valid), .data_o(h_out_data),
    .underrun_o(h_underrun), .mem_addr_o(raddr), .mem_data_i(mem[raddr]),
    .rgray_o(rgray), .wgray_i(wgray), .start_tgl_o(st_tgl), .done_tgl_o(dn_tgl),
    .flush_tgl_i(fl_tgl), .ack_tgl_o(ack_tgl)
  );
endmodule

// File: tb/sim_u2h_pipe_fifo.sv
module sim_u2h_pipe_fifo;
  logic        u_clk = 0, h_clk = 0, u_rst_n = 0, h_rst_n = 0;
  logic        u_wr = 0, u_fifo_rst = 0, h_start = 0, h_out_ready = 0;
  logic [63:0] u_data = '0;
  logic [15:0] h_len = '0;
  logic        u_full, u_start, u_done, h_out_valid, h_underrun;
  logic [8:0]  u_count;
  logic [63:0] h_out_data;

  int checks = 0, errors = 0, start_cnt = 0, done_cnt = 0;
  logic st_prev = 0, dn_prev = 0;
  bit   finished = 0;

  always #5 u_clk = ~u_clk;   // 100 MHz user clock
  always #7 h_clk = ~h_clk;   // unrelated host clock

  u2h_pipe_fifo u0 (.*);

  // stimulus table: words written, length requested, expected underrun
  localparam int NV = 5;
  localparam int VN [NV] = '{4, 1, 8, 3, 0};
  localparam int VL [NV] = '{4, 1, 5, 6, 2};
  localparam bit VU [NV] = '{0, 0, 0, 1, 1};

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // pulse monitors (sampled away from the active edge)
  always @(negedge u_clk) begin
    if (u_start) start_cnt++;
    if (u_done)  done_cnt++;
    if (u_start && st_prev) chk(0, "R2 start pulse width", 2, 1);
    if (u_done && dn_prev)  chk(0, "R8 done pulse width", 2, 1);
    st_prev = u_start;
    dn_prev = u_done;
  end

  initial begin
    repeat (150000) @(posedge u_clk);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  task automatic settle();
    repeat (12) @(negedge u_clk);
  endtask

  task automatic write_words(input int n, input logic [63:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge u_clk);
      u_wr = 1; u_data = base + 64'(i);
    end
    @(negedge u_clk);
    u_wr = 0;
  endtask

  task automatic flush(output int held);
    @(negedge u_clk);
    u_fifo_rst = 1;
    @(negedge u_clk);
    u_fifo_rst = 0;
    held = 0;
    while (u_full) begin
      held++;
      @(negedge u_clk);
    end
  endtask

  task automatic host_start(input int len);
    @(negedge h_clk);
    h_start = 1; h_len = 16'(len);
    @(negedge h_clk);
    h_start = 0;
  endtask

  task automatic pop(input int len, input int nw, input logic [63:0] base);
    h_out_ready = 1;
    for (int i = 0; i < len; i++) begin
      chk(h_out_valid, "R3 valid during transfer", 64'(h_out_valid), 1);
      if (i < nw) chk(h_out_data == base + 64'(i), "R3 word order", h_out_data, base + 64'(i));
      else        chk(h_out_data == '0, "R7 zero filler", h_out_data, 0);
      @(negedge h_clk);
    end
    h_out_ready = 0;
    chk(!h_out_valid, "R3 valid drops after length", 64'(h_out_valid), 0);
  endtask

  initial begin
    int held, s0, d0;
    logic [63:0] base;
    repeat (3) @(negedge u_clk);
    u_rst_n = 1; h_rst_n = 1;
    @(negedge u_clk);
    // R1 reset state
    chk(!u_full && u_count == 0 && !u_start && !u_done, "R1 user reset state", {u_full, u_count}, 0);
    chk(!h_out_valid && !h_underrun, "R1 host reset state", {h_out_valid, h_underrun}, 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      base = 64'hC0DE_0000_0000_0000 | (64'(v) << 32);
      flush(held);
      chk(u_count == 0, "R6 count after flush", u_count, 0);
      write_words(VN[v], base);
      settle();
      chk(u_count == 9'(VN[v]), "R4 count after writes", u_count, VN[v]);
      s0 = start_cnt; d0 = done_cnt;
      host_start(VL[v]);
      chk(!h_underrun, "R7 flag cleared on start", 64'(h_underrun), 0);
      pop(VL[v], VN[v], base);
      chk(h_underrun == VU[v], "R7 underrun flag", 64'(h_underrun), 64'(VU[v]));
      settle();
      chk(start_cnt == s0 + 1, "R2 one start pulse", start_cnt - s0, 1);
      chk(done_cnt == d0 + 1, "R8 one done pulse", done_cnt - d0, 1);
      chk(u_count == 9'((VN[v] > VL[v]) ? VN[v] - VL[v] : 0), "R4 count after reads",
          u_count, (VN[v] > VL[v]) ? VN[v] - VL[v] : 0);
      chk(h_underrun == VU[v], "R7 flag sticky after transfer", 64'(h_underrun), 64'(VU[v]));
    end

    // R5 fill to capacity, extra write discarded
    flush(held);
    base = 64'hF00D_0000_0000_0000;
    write_words(511, base);
    settle();
    chk(u_full, "R5 full at 511", 64'(u_full), 1);
    chk(u_count == 9'd511, "R5 count at capacity", u_count, 511);
    write_words(1, 64'hDEAD_BEEF);
    settle();
    chk(u_count == 9'd511, "R5 write while full discarded", u_count, 511);
    host_start(512);
    pop(512, 511, base);
    chk(h_underrun, "R5 R7 extra word absent, underrun", 64'(h_underrun), 1);
    settle();
    chk(u_count == 0 && !u_full, "R4 drained count", u_count, 0);

    // R6 flush holds full, drops words and concurrent writes
    write_words(5, 64'h55);
    settle();
    @(negedge u_clk);
    u_fifo_rst = 1; u_wr = 1; u_data = 64'h77;
    @(negedge u_clk);
    u_fifo_rst = 0;
    held = 0;
    while (u_full) begin
      held++;
      @(negedge u_clk);
    end
    u_wr = 0;
    chk(held >= 3, "R6 full held at least 3 cycles", held, 3);
    settle();
    chk(u_count == 0, "R6 flush empties, writes during flush dropped", u_count, 0);

    // R2 zero-length start ignored
    s0 = start_cnt;
    host_start(0);
    chk(!h_out_valid, "R2 zero length ignored", 64'(h_out_valid), 0);
    settle();
    chk(start_cnt == s0, "R2 no pulse for zero length", start_cnt - s0, 0);

    // R2 start while busy ignored
    base = 64'hB0B0_0000;
    write_words(3, base);
    settle();
    s0 = start_cnt; d0 = done_cnt;
    host_start(3);
    host_start(9);
    pop(3, 3, base);
    chk(!h_underrun, "R2 busy start kept original length", 64'(h_underrun), 0);
    settle();
    chk(start_cnt == s0 + 1, "R2 busy start gives no pulse", start_cnt - s0, 1);
    chk(done_cnt == d0 + 1, "R8 single done", done_cnt - d0, 1);

    summary();
  end
endmodule